// File: doc/BRIEF.md
# Dual-Master Channel Select Registers

This block holds the control state of a selector that lets one of two upstream bus masters drive a shared downstream bus. Each master has its own register port (write strobe, read strobe, 2-bit register index, 8-bit data). Each master therefore has its own copy of the control register. Each copy shows the master its own ownership and connect bits, and also mirrors the other master's bits as read-only fields.

From the two copies the block derives the committed channel: which master owns the downstream bus, and whether any master is connected at all. A master may ask for a downstream bus initialization together with a switch. The switch is then held back, and an initialization request stays raised until the recovery sequencer reports completion. Each master also gets an interrupt request. It is raised by test bits written by either master, and by a notice that the master has lost ownership to the other one. A parameter fixed at build time picks the state after reset: either master 0 is connected, or nothing is connected.

Top module: `chan_select_regs`

## Requirements
- R1: After a synchronous active-low reset with START_CH0=1, chan_on=1 and chan_sel=0, and master 0 reads 0x04 while master 1 reads 0x08. With START_CH0=0, chan_on=0 and both masters read 0x00. In both variants init_req=0 and int_req=00.
- R2: A write reaches only the copy of the master that issued it, and only when the index is 1. A read at any other index returns 0x00, and a write at any other index changes nothing.
- R3: A read at index 1 returns, for master k: bit0 own owner bit, bit1 the other master's owner bit, bit2 own connect bit, bit3 the other master's connect bit, bit4 own init-request bit, bit5 always 0, bit6 own test bit, bit7 cross test bit. The read data is combinational on the current inputs.
- R4: With no initialization pending, chan_sel equals the XOR of the two owner bits and chan_on equals the XOR of the two connect bits. Both follow a write from the clock edge that samples the write.
- R5: int_req[k] is high while master k's own test bit (bit6) is set, or while the other master's cross test bit (bit7) is set.
- R6: A write with bit4=1 that would change {chan_on, chan_sel} raises init_req and freezes both channel outputs. At the edge that samples init_done, the outputs take the value given by the current registers and init_req falls.
- R7: init_done has no effect while no initialization is pending.
- R8: When a committed change moves a connected bus from master k to the other master, int_req[k] rises. It falls at the next control write by master k, unless a test bit still holds it.
- R9: When both masters write in the same cycle, both writes are applied at that edge, master 0's before master 1's, and the outputs reflect both.
- R10: Writes to bits 1, 3 and 5 are ignored. Bits 1 and 3 keep mirroring the other copy, and bit 5 keeps reading 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| m0_wr | input | 1 | Master 0 write strobe |
| m0_rd | input | 1 | Master 0 read strobe |
| m0_idx | input | 2 | Master 0 register index |
| m0_wdata | input | 8 | Master 0 write data |
| m0_rdata | output | 8 | Master 0 read data |
| m1_wr | input | 1 | Master 1 write strobe |
| m1_rd | input | 1 | Master 1 read strobe |
| m1_idx | input | 2 | Master 1 register index |
| m1_wdata | input | 8 | Master 1 write data |
| m1_rdata | output | 8 | Master 1 read data |
| init_done | input | 1 | Pulse from the recovery sequencer: initialization finished |
| chan_sel | output | 1 | Index of the owning master |
| chan_on | output | 1 | Downstream bus connected |
| init_req | output | 1 | Downstream initialization requested; switch pending |
| int_req | output | 2 | Per-master interrupt request, active high |

## Verification
Register writes, channel commits and loss notices all take effect at the clock edge that samples the strobe or init_done. The outputs therefore show the new value one cycle after the stimulus, and int_req follows through combinational logic from those registers. Read data is combinational on the current strobe and index, and reflects the registers as they stand after the last edge. The bench drives inputs just after the falling edge. A behavioural model updates at the rising edge. All outputs are compared at the next falling edge, and directed checks sample two nanoseconds after the rising edge that follows the stimulus.

// File: rtl/chsel_pkg.sv
// Shared definitions for the channel select registers.
// Assumes an 8-bit control word; bit positions are fixed because masters decode them.
package chsel_pkg;
    localparam int B_MY   = 0;
    localparam int B_NMY  = 1;
    localparam int B_ON   = 2;
    localparam int B_NON  = 3;
    localparam int B_INIT = 4;
    localparam int B_ZERO = 5;
    localparam int B_TST  = 6;
    localparam int B_XTST = 7;

    // Writable state of one master's control copy.
    typedef struct packed {
        logic xtst;
        logic tst;
        logic init;
        logic on;
        logic my;
    } ctrl_t;
endpackage

// File: rtl/chsel_copy.sv
// One master's control register copy.
// Decodes writes at CTRL_IDX, presents the next value combinationally so the
// commit logic can act at the same edge, and assembles the read word with the
// other copy's owner and connect bits mirrored in.
// Assumes DATA_W >= 8.
module chsel_copy
    import chsel_pkg::*;
#(
    parameter int IDX_W    = 2,
    parameter int DATA_W   = 8,
    parameter int CTRL_IDX = 1,
    parameter bit RST_ON   = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic              rd,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    input  logic              other_my,
    input  logic              other_on,
    output ctrl_t             q,
    output ctrl_t             nxt,
    output logic              hit,
    output logic [DATA_W-1:0] rdata
);
    localparam logic [IDX_W-1:0] SEL_IDX = IDX_W'(CTRL_IDX);

    logic unused_ro;
    assign unused_ro = ^{wdata[B_NMY], wdata[B_NON], wdata[B_ZERO]};

    // Write decode: only this copy's own port at the control index.
    assign hit = wr && (idx == SEL_IDX);

    // Next register value after an optional write.
    always_comb begin
        nxt = q;
        if (hit) begin
            nxt.my   = wdata[B_MY];
            nxt.on   = wdata[B_ON];
            nxt.init = wdata[B_INIT];
            nxt.tst  = wdata[B_TST];
            nxt.xtst = wdata[B_XTST];
        end
    end

    // Register update with variant-dependent reset of the connect bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q    <= '0;
            q.on <= RST_ON;
        end else begin
            q <= nxt;
        end
    end

    // Read word assembly; anything off the control index reads zero.
    always_comb begin
        rdata = '0;
        if (rd && (idx == SEL_IDX)) begin
            rdata[B_MY]   = q.my;
            rdata[B_NMY]  = other_my;
            rdata[B_ON]   = q.on;
            rdata[B_NON]  = other_on;
            rdata[B_INIT] = q.init;
            rdata[B_TST]  = q.tst;
            rdata[B_XTST] = q.xtst;
        end
    end
endmodule

// File: rtl/chsel_commit.sv
// Committed channel state.
// Derives the wanted owner and connect state from the next register values,
// applies it at once or holds it until init_done when an initialization was
// asked for, and records which master lost a connected bus.
// Assumes exactly two masters.
module chsel_commit #(
    parameter bit START_CH0 = 1'b1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] want_my,
    input  logic [1:0] want_on,
    input  logic       init_ask,
    input  logic [1:0] ctrl_hit,
    input  logic       init_done,
    output logic       chan_sel,
    output logic       chan_on,
    output logic       init_req,
    output logic [1:0] lost
);
    logic       tgt_sel;
    logic       tgt_on;
    logic       moved;
    logic       take;
    logic [1:0] lost_set;

    // Target state and whether it differs from the committed one.
    assign tgt_sel = want_my[0] ^ want_my[1];
    assign tgt_on  = want_on[0] ^ want_on[1];
    assign moved   = {tgt_on, tgt_sel} != {chan_on, chan_sel};
    assign take    = init_req ? init_done : (moved && !init_ask);

    // Per-master loss detection on a commit.
    for (genvar k = 0; k < 2; k++) begin : g_loss
        assign lost_set[k] = take && chan_on && (chan_sel == 1'(k))
                             && tgt_on && (tgt_sel != 1'(k));
    end

    // Committed channel and pending flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chan_sel <= 1'b0;
            chan_on  <= START_CH0;
            init_req <= 1'b0;
        end else begin
            if (take) begin
                chan_sel <= tgt_sel;
                chan_on  <= tgt_on;
            end
            init_req <= init_req ? !init_done : (moved && init_ask);
        end
    end

    // Loss flags: set on losing commit, cleared by the loser's control write.
    always_ff @(posedge clk) begin
        if (!rst_n) lost <= '0;
        else        lost <= lost_set | (lost & ~ctrl_hit);
    end
endmodule

// File: rtl/chsel_irq.sv
// Interrupt request combiner: own test bit, the other master's cross test bit
// and the loss flag each raise a master's request.
// Assumes two masters; index 1-k is the other master.
module chsel_irq #(
    parameter int NM = 2
) (
    input  logic [NM-1:0] tst,
    input  logic [NM-1:0] xtst,
    input  logic [NM-1:0] lost,
    output logic [NM-1:0] int_req
);
    for (genvar k = 0; k < NM; k++) begin : g_req
        assign int_req[k] = tst[k] | xtst[NM-1-k] | lost[k];
    end
endmodule

// File: rtl/chan_select_regs.sv
// Top of the dual-master channel select registers.
// Two mirrored control copies, one commit stage and an interrupt combiner.
// Assumes both register ports are synchronous to clk.
module chan_select_regs
    import chsel_pkg::*;
#(
    parameter int IDX_W     = 2,
    parameter int DATA_W    = 8,
    parameter int CTRL_IDX  = 1,
    parameter bit START_CH0 = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              m0_wr,
    input  logic              m0_rd,
    input  logic [IDX_W-1:0]  m0_idx,
    input  logic [DATA_W-1:0] m0_wdata,
    output logic [DATA_W-1:0] m0_rdata,
    input  logic              m1_wr,
    input  logic              m1_rd,
    input  logic [IDX_W-1:0]  m1_idx,
    input  logic [DATA_W-1:0] m1_wdata,
    output logic [DATA_W-1:0] m1_rdata,
    input  logic              init_done,
    output logic              chan_sel,
    output logic              chan_on,
    output logic              init_req,
    output logic [1:0]        int_req
);
    localparam int NM = 2;

    logic [NM-1:0]             p_wr, p_rd, hit, reg_my, reg_on, reg_tst, reg_xtst;
    logic [NM-1:0]             nxt_my, nxt_on, nxt_init, lost;
    logic [NM-1:0][IDX_W-1:0]  p_idx;
    logic [NM-1:0][DATA_W-1:0] p_wdata, p_rdata;
    ctrl_t                     q   [NM];
    ctrl_t                     nxt [NM];

    // Gather per-master ports into arrays.
    assign p_wr    = {m1_wr, m0_wr};
    assign p_rd    = {m1_rd, m0_rd};
    assign p_idx   = {m1_idx, m0_idx};
    assign p_wdata = {m1_wdata, m0_wdata};
    assign m0_rdata = p_rdata[0];
    assign m1_rdata = p_rdata[1];

    for (genvar k = 0; k < NM; k++) begin : g_copy
        chsel_copy #(
            .IDX_W(IDX_W), .DATA_W(DATA_W), .CTRL_IDX(CTRL_IDX),
            .RST_ON((k == 0) && START_CH0)
        ) u_copy (
            .clk(clk), .rst_n(rst_n),
            .wr(p_wr[k]), .rd(p_rd[k]), .idx(p_idx[k]), .wdata(p_wdata[k]),
            .other_my(reg_my[NM-1-k]), .other_on(reg_on[NM-1-k]),
            .q(q[k]), .nxt(nxt[k]), .hit(hit[k]), .rdata(p_rdata[k])
        );
        assign reg_my[k]   = q[k].my;
        assign reg_on[k]   = q[k].on;
        assign reg_tst[k]  = q[k].tst;
        assign reg_xtst[k] = q[k].xtst;
        assign nxt_my[k]   = nxt[k].my;
        assign nxt_on[k]   = nxt[k].on;
        assign nxt_init[k] = nxt[k].init & hit[k];
    end

    chsel_commit #(.START_CH0(START_CH0)) u_commit (
        .clk(clk), .rst_n(rst_n),
        .want_my(nxt_my), .want_on(nxt_on), .init_ask(|nxt_init),
        .ctrl_hit(hit), .init_done(init_done),
        .chan_sel(chan_sel), .chan_on(chan_on), .init_req(init_req), .lost(lost)
    );

    chsel_irq #(.NM(NM)) u_irq (
        .tst(reg_tst), .xtst(reg_xtst), .lost(lost), .int_req(int_req)
    );
endmodule

// File: rtl/chan_select_regs_chk.sv
// Property checker for chan_select_regs, attached by bind below.
module chan_select_regs_chk #(
    parameter int IDX_W  = 2,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              m0_wr,
    input logic              m1_wr,
    input logic              m0_rd,
    input logic [IDX_W-1:0]  m0_idx,
    input logic [DATA_W-1:0] m0_rdata,
    input logic [DATA_W-1:0] m1_rdata,
    input logic              init_done,
    input logic              chan_sel,
    input logic              chan_on,
    input logic              init_req,
    input logic [1:0]        int_req,
    input logic [1:0]        reg_my,
    input logic [1:0]        reg_on,
    input logic [1:0]        reg_tst
);
    assert_commit_match_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !init_req |-> (chan_on == (reg_on[0] ^ reg_on[1])) && (chan_sel == (reg_my[0] ^ reg_my[1])));

    assert_hold_pending_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (init_req && !init_done) |=> ($stable(chan_sel) && $stable(chan_on)));

    assert_done_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (init_req && init_done) |=> !init_req);

    assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!init_req && init_done && !m0_wr && !m1_wr) |=> ($stable(chan_sel) && $stable(chan_on) && !init_req));

    assert_test_irq_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_tst != 2'b00) |-> ((int_req & reg_tst) == reg_tst));

    assert_zero_bit_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (m0_rdata[5] == 1'b0) && (m1_rdata[5] == 1'b0));

    assert_other_idx_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (m0_rd && (m0_idx != IDX_W'(1))) |-> (m0_rdata == '0));
endmodule

bind chan_select_regs chan_select_regs_chk #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .m0_wr(m0_wr), .m1_wr(m1_wr), .m0_rd(m0_rd),
    .m0_idx(m0_idx), .m0_rdata(m0_rdata), .m1_rdata(m1_rdata),
    .init_done(init_done), .chan_sel(chan_sel), .chan_on(chan_on),
    .init_req(init_req), .int_req(int_req),
    .reg_my(reg_my), .reg_on(reg_on), .reg_tst(reg_tst)
);

// File: tb/test_chan_select_regs.sv
module test_chan_select_regs;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic       m0_wr = 0, m0_rd = 0, m1_wr = 0, m1_rd = 0, init_done = 0;
    logic [1:0] m0_idx = 0, m1_idx = 0;
    logic [7:0] m0_wdata = 0, m1_wdata = 0;
    logic [7:0] m0_rdata, m1_rdata, off_rd0, off_rd1;
    logic       chan_sel, chan_on, init_req, off_sel, off_on, off_ireq;
    logic [1:0] int_req, off_int;

    int total = 0;
    int bad = 0;
    bit live = 0;

    always #4 clk = ~clk;

    chan_select_regs i_chan_select_regs (
        .clk(clk), .rst_n(rst_n),
        .m0_wr(m0_wr), .m0_rd(m0_rd), .m0_idx(m0_idx), .m0_wdata(m0_wdata), .m0_rdata(m0_rdata),
        .m1_wr(m1_wr), .m1_rd(m1_rd), .m1_idx(m1_idx), .m1_wdata(m1_wdata), .m1_rdata(m1_rdata),
        .init_done(init_done), .chan_sel(chan_sel), .chan_on(chan_on),
        .init_req(init_req), .int_req(int_req)
    );

    // Variant with nothing connected after reset; ports otherwise idle.
    chan_select_regs #(.START_CH0(1'b0)) i_chan_select_regs_off (
        .clk(clk), .rst_n(rst_n),
        .m0_wr(1'b0), .m0_rd(1'b1), .m0_idx(2'd1), .m0_wdata(8'h00), .m0_rdata(off_rd0),
        .m1_wr(1'b0), .m1_rd(1'b1), .m1_idx(2'd1), .m1_wdata(8'h00), .m1_rdata(off_rd1),
        .init_done(1'b0), .chan_sel(off_sel), .chan_on(off_on),
        .init_req(off_ireq), .int_req(off_int)
    );

    // Behavioural reference state.
    int mb[2], bo[2], ts[2], xt[2], bi[2], lo[2];
    int a_on, a_sel, pend;

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int exp_rd(input int k, input int rd, input int idx);
        if (rd == 0 || idx != 1) return 0;
        return xt[k]*128 + ts[k]*64 + bi[k]*16 + bo[1-k]*8 + bo[k]*4 + mb[1-k]*2 + mb[k];
    endfunction

    function automatic int exp_int(input int k);
        return (ts[k] | xt[1-k] | lo[k]);
    endfunction

    // Model update at every rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < 2; k++) begin
                mb[k] = 0; bo[k] = 0; ts[k] = 0; xt[k] = 0; bi[k] = 0; lo[k] = 0;
            end
            bo[0] = 1; a_on = 1; a_sel = 0; pend = 0;
        end else begin
            int ask, w_on, w_sel, go, hitk[2];
            int wv[2], wd[2], wi[2];
            wv[0] = m0_wr; wd[0] = m0_wdata; wi[0] = m0_idx;
            wv[1] = m1_wr; wd[1] = m1_wdata; wi[1] = m1_idx;
            ask = 0;
            for (int k = 0; k < 2; k++) begin
                hitk[k] = (wv[k] != 0 && wi[k] == 1);
                if (hitk[k] != 0) begin
                    mb[k] = wd[k] & 1; bo[k] = (wd[k] >> 2) & 1; bi[k] = (wd[k] >> 4) & 1;
                    ts[k] = (wd[k] >> 6) & 1; xt[k] = (wd[k] >> 7) & 1;
                    if (bi[k] != 0) ask = 1;
                end
            end
            w_on = bo[0] ^ bo[1];
            w_sel = mb[0] ^ mb[1];
            if (pend != 0) go = init_done;
            else go = ((w_on != a_on || w_sel != a_sel) && ask == 0) ? 1 : 0;
            for (int k = 0; k < 2; k++) begin
                if (hitk[k] != 0) lo[k] = 0;
                if (go != 0 && a_on == 1 && a_sel == k && w_on == 1 && w_sel != k) lo[k] = 1;
            end
            if (pend != 0) pend = init_done ? 0 : 1;
            else pend = ((w_on != a_on || w_sel != a_sel) && ask != 0) ? 1 : 0;
            if (go != 0) begin a_on = w_on; a_sel = w_sel; end
        end
    end

    // Cycle compare at every falling edge.
    always @(negedge clk) begin
        if (live && rst_n) begin
            chk("R4/R6 chan_on", chan_on, a_on);
            chk("R4/R6 chan_sel", chan_sel, a_sel);
            chk("R6 init_req", init_req, pend);
            chk("R5/R8 int_req0", int_req[0], exp_int(0));
            chk("R5/R8 int_req1", int_req[1], exp_int(1));
            chk("R3 m0_rdata", m0_rdata, exp_rd(0, m0_rd, m0_idx));
            chk("R3 m1_rdata", m1_rdata, exp_rd(1, m1_rd, m1_idx));
        end
    end

    task automatic drive(input bit w0, input int i0, input int d0,
                         input bit w1, input int i1, input int d1, input bit dn);
        @(negedge clk); #1;
        m0_wr = w0; m0_idx = 2'(i0); m0_wdata = 8'(d0);
        m1_wr = w1; m1_idx = 2'(i1); m1_wdata = 8'(d1);
        init_done = dn;
    endtask

    task automatic after_edge();
        @(posedge clk); #2;
    endtask

    task automatic idle();
        drive(0, 1, 0, 0, 1, 0, 0);
        after_edge();
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        m0_rd = 1; m1_rd = 1; m0_idx = 1; m1_idx = 1;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        live = 1;
        #1;
        // R1: reset state, both variants
        chk("R1 chan_on", chan_on, 1);
        chk("R1 chan_sel", chan_sel, 0);
        chk("R1 m0 read", m0_rdata, 8'h04);
        chk("R1 m1 read", m1_rdata, 8'h08);
        chk("R1 int_req", int_req, 0);
        chk("R1 init_req", init_req, 0);
        chk("R1 off chan_on", off_on, 0);
        chk("R1 off m0 read", off_rd0, 0);
        chk("R1 off m1 read", off_rd1, 0);

        // R10: read-only bits ignored
        drive(1, 1, 8'h2E, 0, 1, 0, 0); after_edge();
        chk("R10 m0 read", m0_rdata, 8'h04);
        chk("R10 chan_on", chan_on, 1);

        // R9: same-cycle writes, master 1 takes over
        drive(1, 1, 8'h05, 1, 1, 8'h00, 0); after_edge();
        chk("R9 chan_sel", chan_sel, 1);
        chk("R9 chan_on", chan_on, 1);
        chk("R8 int_req loser", int_req, 2'b01);

        // R8: loser's control write clears its notice
        drive(1, 1, 8'h05, 0, 1, 0, 0); after_edge();
        chk("R8 int_req cleared", int_req, 2'b00);

        // R6: switch held until init_done
        drive(0, 1, 0, 1, 1, 8'h11, 0); after_edge();
        chk("R6 init_req", init_req, 1);
        chk("R6 held sel", chan_sel, 1);
        idle(); idle();
        chk("R6 still held", chan_sel, 1);
        drive(0, 1, 0, 0, 1, 0, 1); after_edge();
        chk("R6 committed sel", chan_sel, 0);
        chk("R6 init_req low", init_req, 0);
        chk("R8 int_req m1 lost", int_req, 2'b10);

        // R7: init_done without a pending switch
        drive(0, 1, 0, 0, 1, 0, 1); after_edge();
        chk("R7 sel", chan_sel, 0);
        chk("R7 init_req", init_req, 0);

        // R5: test bits
        drive(0, 1, 0, 1, 1, 8'h01, 0); after_edge();
        chk("R8 m1 cleared", int_req, 2'b00);
        drive(1, 1, 8'h45, 0, 1, 0, 0); after_edge();
        chk("R5 own test", int_req, 2'b01);
        drive(1, 1, 8'h85, 0, 1, 0, 0); after_edge();
        chk("R5 cross test", int_req, 2'b10);
        drive(1, 1, 8'h05, 0, 1, 0, 0); after_edge();

        // R2: other index ignored and reads zero
        drive(1, 2, 8'h00, 0, 1, 0, 0); after_edge();
        chk("R2 chan_on", chan_on, 1);
        drive(0, 0, 0, 0, 1, 0, 0);
        m0_idx = 0; #1;
        chk("R2 read idx0", m0_rdata, 0);
        after_edge();

        // Mixed traffic against the model.
        for (int n = 0; n < 3000; n++) begin
            int r0, r1, d0, d1;
            r0 = $urandom_range(0, 99); r1 = $urandom_range(0, 99);
            d0 = $urandom_range(0, 255); d1 = $urandom_range(0, 255);
            if ($urandom_range(0, 99) < 60) begin d0 = d0 & 8'hEF; d1 = d1 & 8'hEF; end
            if ($urandom_range(0, 99) < 50) begin d0 = d0 & 8'h3F; d1 = d1 & 8'h3F; end
            drive(r0 < 25, (r0 < 3) ? 2 : 1, d0, r1 < 25, (r1 < 3) ? 3 : 1, d1,
                  $urandom_range(0, 99) < 12);
            m0_rd = ($urandom_range(0, 3) != 0); m1_rd = ($urandom_range(0, 3) != 0);
        end
        idle();
        finish_run();
    end
endmodule